// File: doc/BRIEF.md
# Host interrupt status and mask controller

This block gathers sixteen event lines from device-side logic and hands them to a host processor through a small register port. Each event line is watched for a rising edge. When one appears, the matching status bit is latched and stays set until the host clears it. A mask register decides which latched bits may raise the single host interrupt line. The polarity of that line is set by an input pin.

The host sees one status latch through two read addresses. A read of the peek address leaves the latch unchanged. A read of the drain address returns the same value and then empties the latch. The host can also clear chosen bits by writing ones to an acknowledge address. The mask can be loaded in one write, or changed bit by bit through a set address and a clear address, so one handler can change its own bits without a read-modify-write. Only bits 0 to 10 and bit 14 are live event positions. Every other status bit is reserved.

The register port is synchronous. Writes take effect at the clock edge where the write enable is high. Read data is registered and is valid in the cycle after the read enable.

Top module: `irq_host_ctrl`

## Requirements
- R1: After reset the mask reads 0x0001, every status bit is 0, and the host interrupt output is at its inactive level.
- R2: A write to address 0 loads the mask with the write data. A read of address 0 returns the mask one cycle after the read enable.
- R3: A write to address 1 sets each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R4: A write to address 2 clears each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R5: A read of address 3 returns the status bits and changes neither the status nor the mask.
- R6: A read of address 4 returns the status bits as they were before the read, and every status bit is 0 afterwards unless a new event arrives in that same cycle.
- R7: A write to address 5 clears each status bit whose data bit is 1. Data bits of 0 have no effect. The result is the same whichever status address is read.
- R8: A status bit is set by a 0-to-1 transition of its event line. An event line that stays high does not set the bit again after it has been cleared.
- R9: When an event edge arrives in the same cycle as an acknowledge or a drain read that clears its bit, the bit ends up set.
- R10: The interrupt output is active exactly when some status bit is 1 and its mask bit is 0. The active level is high when pol_low_i is 0 and low when pol_low_i is 1.
- R11: Status bits 11, 12, 13 and 15 always read as 0 and never raise the interrupt, whatever their event lines do.
- R12: Reads of addresses 1, 2, 5, 6 and 7 return 0. Writes to addresses 3, 4, 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block |
| evt_i | input | 16 | Device event lines. A rising edge latches the matching status bit |
| pol_low_i | input | 1 | 1 makes the interrupt active-low, 0 makes it active-high |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data, valid one cycle after rd_en_i |
| irq_o | output | 1 | Host interrupt level |

## Verification
The bench aims at the cycle in which a new event edge meets a drain read or an acknowledge. A design that lets the clear win would drop that event, and the next peek would show 0 where the reference model expects the bit. It holds event lines high across clears, which catches level-triggered latching, because that bit would reappear at once. It also checks that a drain read returns the value from before the clear: a design that clears too early would return 0. Writes of zero to the set, clear and acknowledge ports, writes to the read-only addresses, reserved event lines, and changes of polarity while an interrupt is pending are all compared against the model, so a stray bit or an inverted output shows up as a mismatch.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_MASK   = 3'd0,
    SEL_MSET   = 3'd1,
    SEL_MCLR   = 3'd2,
    SEL_PEEK   = 3'd3,
    SEL_DRAIN  = 3'd4,
    SEL_ACK    = 3'd5,
    SEL_RSV6   = 3'd6,
    SEL_RSV7   = 3'd7
  } reg_sel_e;

  // Live event positions: 0..10 and 14
  localparam logic [15:0] LIVE_EVT_DEF = 16'h47FF;
  localparam logic [15:0] MASK_RST_DEF = 16'h0001;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] rise_o
);

  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  always_comb begin
    prev_d = evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= prev_d;
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_rise
      assign rise_o[g] = evt_i[g] & ~prev_q[g];
    end
  endgenerate

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N       = 16,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o
);

  logic [N-1:0] mask_q;
  logic [N-1:0] mask_d;
  logic         mask_en;

  assign mask_en = load_i | set_i | clr_i;

  always_comb begin
    mask_d = mask_q;
    if (load_i)      mask_d = wdata_i;
    else if (set_i)  mask_d = mask_q | wdata_i;
    else if (clr_i)  mask_d = mask_q & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= RST_VAL;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> mask_q == $past(wdata_i));                                  // R2
  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !load_i |=> (mask_q & $past(wdata_i)) == $past(wdata_i));     // R3
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !load_i && !set_i |=> (mask_q & $past(wdata_i)) == '0);       // R4

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned  N    = 16,
  parameter logic [N-1:0] LIVE = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] ack_i,
  input  logic         drain_i,
  output logic [N-1:0] status_o
);

  logic [N-1:0] status_q;
  logic [N-1:0] status_d;
  logic [N-1:0] set_v;
  logic [N-1:0] clr_v;
  logic         status_en;

  assign set_v     = rise_i & LIVE;
  assign clr_v     = drain_i ? {N{1'b1}} : ack_i;
  assign status_en = (|set_v) | (|clr_v);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      if (LIVE[g]) begin : g_live
        always_comb begin
          // a new edge beats a clear in the same cycle
          status_d[g] = set_v[g] | (status_q[g] & ~clr_v[g]);
        end
      end else begin : g_rsv
        always_comb begin
          status_d[g] = 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  assign status_o = status_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(rise_i & LIVE)) |=> (status_q & $past(rise_i & LIVE)) == $past(rise_i & LIVE)); // R9
  AST_DRAIN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_i && ((rise_i & LIVE) == '0) |=> status_q == '0);                 // R6
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack_i) |=> (status_q & $past(ack_i & ~rise_i)) == '0);                // R7
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drain_i && ack_i == '0 && ((rise_i & LIVE) == '0) |=> $stable(status_q)); // R5

endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_pkg::*;
#(
  parameter int unsigned  N    = 16,
  parameter logic [N-1:0] LIVE = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      mask_i,
  input  logic [N-1:0]      status_i,
  output logic              mask_load_o,
  output logic              mask_set_o,
  output logic              mask_clr_o,
  output logic [N-1:0]      ack_o,
  output logic              drain_o,
  output logic [N-1:0]      rdata_o
);

  reg_sel_e     sel;
  logic [N-1:0] rdata_q;
  logic [N-1:0] rdata_d;

  assign sel = reg_sel_e'(addr_i);

  always_comb begin
    mask_load_o = 1'b0;
    mask_set_o  = 1'b0;
    mask_clr_o  = 1'b0;
    ack_o       = '0;
    if (wr_en_i) begin
      unique case (sel)
        SEL_MASK: mask_load_o = 1'b1;
        SEL_MSET: mask_set_o  = 1'b1;
        SEL_MCLR: mask_clr_o  = 1'b1;
        SEL_ACK:  ack_o       = wdata_i;
        default:  ;
      endcase
    end
  end

  assign drain_o = rd_en_i && (sel == SEL_DRAIN);

  always_comb begin
    unique case (sel)
      SEL_MASK:  rdata_d = mask_i;
      SEL_PEEK:  rdata_d = status_i;
      SEL_DRAIN: rdata_d = status_i;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  AST_RSV_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (sel == SEL_PEEK || sel == SEL_DRAIN) |=> (rdata_q & ~LIVE) == '0); // R11
  AST_WO_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (sel == SEL_MSET || sel == SEL_MCLR || sel == SEL_ACK) |=> rdata_q == '0); // R12

endmodule

// File: rtl/irq_host_ctrl.sv
module irq_host_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned  NUM_EVT  = 16,
  parameter logic [NUM_EVT-1:0] LIVE_EVT = LIVE_EVT_DEF,
  parameter logic [NUM_EVT-1:0] MASK_RST = MASK_RST_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               pol_low_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [NUM_EVT-1:0] wdata_i,
  output logic [NUM_EVT-1:0] rdata_o,
  output logic               irq_o
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_sync_q[SYNC_STAGES-1];

  logic [NUM_EVT-1:0] rise;
  logic [NUM_EVT-1:0] mask;
  logic [NUM_EVT-1:0] status;
  logic [NUM_EVT-1:0] ack;
  logic               mask_load;
  logic               mask_set;
  logic               mask_clr;
  logic               drain;
  logic               pending;

  irq_edge_detect #(.N(NUM_EVT)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .evt_i  (evt_i),
    .rise_o (rise)
  );

  irq_mask_reg #(.N(NUM_EVT), .RST_VAL(MASK_RST)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .load_i  (mask_load),
    .set_i   (mask_set),
    .clr_i   (mask_clr),
    .wdata_i (wdata_i),
    .mask_o  (mask)
  );

  irq_status_reg #(.N(NUM_EVT), .LIVE(LIVE_EVT)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .rise_i   (rise),
    .ack_i    (ack),
    .drain_i  (drain),
    .status_o (status)
  );

  irq_regif #(.N(NUM_EVT), .LIVE(LIVE_EVT)) u_regif (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .addr_i      (addr_i),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .wdata_i     (wdata_i),
    .mask_i      (mask),
    .status_i    (status),
    .mask_load_o (mask_load),
    .mask_set_o  (mask_set),
    .mask_clr_o  (mask_clr),
    .ack_o       (ack),
    .drain_o     (drain),
    .rdata_o     (rdata_o)
  );

  assign pending = |(status & ~mask);
  assign irq_o   = pol_low_i ? ~pending : pending;

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((status & ~mask) == '0) |-> (irq_o == pol_low_i));                     // R10
  AST_RESET_STATE: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rst_n) |-> (mask == MASK_RST) && (status == '0));                // R1

endmodule

// File: tb/sim_irq_host_ctrl.sv
module sim_irq_host_ctrl;

  localparam logic [15:0] LIVE = 16'h47FF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] evt;
  logic        pol_low;
  logic [2:0]  addr;
  logic        wr_en;
  logic        rd_en;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  logic [15:0] m_mask, m_stat, m_prev;

  always #5 clk = ~clk;

  irq_host_ctrl u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .evt_i     (evt),
    .pol_low_i (pol_low),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .rd_en_i   (rd_en),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .irq_o     (irq)
  );

  function automatic logic [15:0] read_val(input logic [2:0] a, input logic [15:0] mk,
                                           input logic [15:0] st);
    case (a)
      3'd0:    return mk;
      3'd3:    return st;
      3'd4:    return st;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] next_mask(input logic [15:0] mk, input logic w,
                                            input logic [2:0] a, input logic [15:0] d);
    if (!w) return mk;
    case (a)
      3'd0:    return d;
      3'd1:    return mk | d;
      3'd2:    return mk & ~d;
      default: return mk;
    endcase
  endfunction

  function automatic logic [15:0] next_stat(input logic [15:0] st, input logic [15:0] rise,
                                            input logic w, input logic r,
                                            input logic [2:0] a, input logic [15:0] d);
    logic [15:0] c;
    c = 16'h0;
    if (w && a == 3'd5) c = d;
    if (r && a == 3'd4) c = 16'hFFFF;
    return ((st & ~c) | rise) & LIVE;
  endfunction

  function automatic logic exp_irq(input logic [15:0] st, input logic [15:0] mk,
                                   input logic pl);
    return pl ^ (|(st & ~mk));
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive after the falling edge, compare after the rising edge
  task automatic cyc(input string tag, input logic [15:0] e, input logic w,
                     input logic r, input logic [2:0] a, input logic [15:0] d);
    logic [15:0] rise, exp_rd, nm, ns;
    @(negedge clk);
    evt = e; wr_en = w; rd_en = r; addr = a; wdata = d;
    rise   = e & ~m_prev & LIVE;
    exp_rd = read_val(a, m_mask, m_stat);
    nm     = next_mask(m_mask, w, a, d);
    ns     = next_stat(m_stat, rise, w, r, a, d);
    @(posedge clk);
    #1;
    m_prev = e; m_mask = nm; m_stat = ns;
    if (r) check(tag, rdata, exp_rd);
    check("R10 irq", {15'h0, irq}, {15'h0, exp_irq(m_stat, m_mask, pol_low)});
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; evt = '0; pol_low = 1'b0; addr = '0;
    wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    m_mask = 16'h0001; m_stat = '0; m_prev = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 irq idle", {15'h0, irq}, 16'h0);
    cyc("R1 mask reset", '0, 0, 1, 3'd0, '0);
    cyc("R1 status reset", '0, 0, 1, 3'd3, '0);

    // R2 direct load, R3 set, R4 clear
    cyc("R2 load", '0, 1, 0, 3'd0, 16'hA5A5);
    cyc("R2 readback", '0, 0, 1, 3'd0, '0);
    cyc("R3 set", '0, 1, 0, 3'd1, 16'h0F00);
    cyc("R3 readback", '0, 0, 1, 3'd0, '0);
    cyc("R4 clear", '0, 1, 0, 3'd2, 16'h00FF);
    cyc("R4 readback", '0, 0, 1, 3'd0, '0);
    cyc("R3 zero set", '0, 1, 0, 3'd1, 16'h0000);
    cyc("R4 zero clr", '0, 1, 0, 3'd2, 16'h0000);
    cyc("R4 zero readback", '0, 0, 1, 3'd0, '0);
    cyc("R10 unmask all", '0, 1, 0, 3'd0, 16'h0000);

    // R8 edge latch, R11 reserved lines, R5 peek
    cyc("R8 edge", 16'hB801, 0, 0, 3'd0, '0);
    cyc("R5 peek", 16'hB801, 0, 1, 3'd3, '0);
    cyc("R5 peek again", 16'hB801, 0, 1, 3'd3, '0);
    cyc("R11 reserved", 16'hB801, 0, 1, 3'd4, '0);
    cyc("R8 level held", 16'hB801, 0, 1, 3'd3, '0);
    // R7 acknowledge
    cyc("R7 edge", 16'h4006, 0, 0, 3'd0, '0);
    cyc("R7 ack", 16'h4006, 1, 0, 3'd5, 16'h0002);
    cyc("R7 peek", 16'h4006, 0, 1, 3'd3, '0);
    cyc("R7 drain view", 16'h4006, 0, 1, 3'd4, '0);
    // R9 set beats drain and ack
    cyc("R9 pre", 16'h0000, 0, 0, 3'd0, '0);
    cyc("R9 arm", 16'h0010, 0, 0, 3'd0, '0);
    cyc("R9 drain+edge", 16'h0030, 0, 1, 3'd4, '0);
    cyc("R9 peek", 16'h0030, 0, 1, 3'd3, '0);
    cyc("R9 ack+edge", 16'h0070, 1, 0, 3'd5, 16'h0070);
    cyc("R9 peek2", 16'h0070, 0, 1, 3'd3, '0);
    // R12 write-only reads and ignored writes
    cyc("R12 rd set", '0, 0, 1, 3'd1, '0);
    cyc("R12 rd ack", '0, 0, 1, 3'd5, '0);
    cyc("R12 rd 7", '0, 0, 1, 3'd7, '0);
    cyc("R12 wr peek", '0, 1, 0, 3'd3, 16'hFFFF);
    cyc("R12 wr 6", '0, 1, 0, 3'd6, 16'hFFFF);
    cyc("R12 status", '0, 0, 1, 3'd3, '0);
    cyc("R12 mask", '0, 0, 1, 3'd0, '0);
    // R10 polarity while pending
    pol_low = 1'b1;
    cyc("R10 low", '0, 0, 1, 3'd3, '0);
    cyc("R10 mask all", '0, 1, 0, 3'd0, 16'hFFFF);
    pol_low = 1'b0;
    cyc("R10 high", '0, 1, 0, 3'd2, 16'h0040);

    // random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] e;
      logic w, r;
      logic [2:0] a;
      e = evt ^ ($urandom & $urandom & $urandom);
      w = ($urandom % 3) == 0;
      r = ($urandom % 2) == 0;
      a = 3'($urandom % 8);
      if (i % 500 == 250) pol_low = ~pol_low;
      cyc((a == 3'd0) ? "R2 rand" : (a == 3'd3) ? "R5 rand" :
          (a == 3'd4) ? "R6 rand" : "R12 rand", e, w, r, a, 16'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule